// File: doc/BRIEF.md
# Feedforward Arbiter Delay-Race Response Generator

This block is a cycle-based digital model of a delay-race unclonable function. A challenge word is taken over a valid/ready handshake. It is scrambled by a fixed shift-register mixer into one switch-control bit per stage. Each of several chains then runs a race between two edges through a line of two-way switch stages. A stage either passes both edges straight through or swaps them, and each pass adds an integer delay. Those delays come from a per-chain pseudorandom generator started from the instance seed, and they stand in for manufacturing variation.

At one intermediate stage a tap arbiter records which edge leads. That decision overrides the control bit of a later stage. The final arbiter decision of every chain is folded together by XOR into a single response bit. The response is offered over a second valid/ready handshake. It holds until it is taken, and no new challenge is accepted until then.

Top module: `ff_arb_puf`

## Requirements
- R1: After reset, `ch_ready` is 1 and `rsp_valid` is 0.
- R2: A challenge is accepted on a cycle with `ch_valid` and `ch_ready` both 1. From the next cycle `ch_ready` stays 0 until the response is taken. A challenge offered during that time is not accepted, and the response returned is the one for the first challenge.
- R3: `rsp_valid` first rises exactly MIX_CYC + CW clock cycles after the accepting edge. With the defaults this is 16 + 128 = 144 cycles.
- R4: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_bit` stays unchanged. After an edge where both are 1, the block is idle again, with `ch_ready` = 1 and `rsp_valid` = 0.
- R5: Expansion works as follows. The mixer register is loaded with `ch_data` and then shifted MIX_CYC times. Each shift gives next = {m[CW-2:0], m[CW-1]^m[CW-3]^m[CW-28]^m[CW-30]}, which means taps 127, 125, 100 and 98 for CW = 128. Bit k of the result controls stage k.
- R6: Stage k has control c. If c = 0, the upper time gains s[DW-1:0] and the lower time gains s[2DW-1:DW]. If c = 1, the new upper time is old lower + s[3DW-1:2DW], and the new lower time is old upper + s[4DW-1:3DW]. Here s is the chain generator state before stage k. The generator steps once per stage as s = {s[30:0], s[31]^s[21]^s[1]^s[0]}, and both times start at 0.
- R7: An arbiter decides 1 only when the upper time is strictly less than the lower time. An exact tie decides 0.
- R8: After stage FF_TAP (default 63) is processed, the arbiter decision at that point replaces the control bit of stage FF_DST (default 100).
- R9: Chain j starts its generator at `inst_seed` ^ (32'h9E3779B9 × (j+1)) mod 2^32, with 1 used if that value is 0. `rsp_bit` is the XOR of the final decisions of all NCH chains.
- R10: The same challenge and seed always give the same response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Challenge offered |
| ch_ready | output | 1 | Block idle, challenge can be taken |
| ch_data | input | CW | Challenge word |
| inst_seed | input | 32 | Per-instance delay seed, sampled at challenge acceptance |
| rsp_valid | output | 1 | Response bit available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_bit | output | 1 | XOR-compressed race result |

## Verification
Every response is due exactly MIX_CYC + CW edges after its accepting edge. The bench counts rising edges from acceptance and reads the outputs one time unit after each edge. It compares that count with 144 and the bit with a model built from R5 to R9. Back-pressure and the return to idle are each checked one edge after the stimulus that causes them. Refused challenges are checked on every busy cycle, while `ch_ready` is 0.

// File: rtl/puf_pkg.sv
package puf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MIX  = 2'd1,
    PH_RACE = 2'd2,
    PH_HOLD = 2'd3
  } phase_t;

  localparam logic [31:0] SALT_STEP = 32'h9E3779B9;

  function automatic logic [31:0] gen_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/puf_mixer.sv
module puf_mixer #(
  parameter int CW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] din,
  input  logic          shift,
  output logic [CW-1:0] ctl
);
  localparam int T0 = CW - 1;
  localparam int T1 = CW - 3;
  localparam int T2 = CW - 28;
  localparam int T3 = CW - 30;

  logic [CW-1:0] m_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     m_q <= '0;
    else if (load)  m_q <= din;
    else if (shift) m_q <= {m_q[CW-2:0], m_q[T0] ^ m_q[T1] ^ m_q[T2] ^ m_q[T3]};
  end

  assign ctl = m_q;
endmodule

// File: rtl/puf_race_chain.sv
module puf_race_chain
  import puf_pkg::*;
#(
  parameter int          CW     = 128,
  parameter int          DW     = 4,
  parameter int          FF_TAP = 63,
  parameter int          FF_DST = 100,
  parameter int          TW     = 12,
  parameter logic [31:0] SALT   = 32'h1,
  localparam int         SW     = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   seed,
  input  logic          step,
  input  logic [SW-1:0] idx,
  input  logic [CW-1:0] ctl,
  output logic          lead
);
  logic [31:0]   s_q, s_init;
  logic [TW-1:0] up_q, lo_q, up_n, lo_n;
  logic [TW-1:0] d_su, d_sl, d_xu, d_xl;
  logic          ff_q, c;

  assign s_init = ((seed ^ SALT) == 32'h0) ? 32'h1 : (seed ^ SALT);

  always_comb begin
    d_su = TW'(s_q[0*DW +: DW]);
    d_sl = TW'(s_q[1*DW +: DW]);
    d_xu = TW'(s_q[2*DW +: DW]);
    d_xl = TW'(s_q[3*DW +: DW]);
    c    = (idx == SW'(FF_DST)) ? ff_q : ctl[idx];
    if (c) begin
      up_n = lo_q + d_xu;
      lo_n = up_q + d_xl;
    end else begin
      up_n = up_q + d_su;
      lo_n = lo_q + d_sl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q  <= 32'h1;
      up_q <= '0;
      lo_q <= '0;
      ff_q <= 1'b0;
    end else if (load) begin
      s_q  <= s_init;
      up_q <= '0;
      lo_q <= '0;
      ff_q <= 1'b0;
    end else if (step) begin
      s_q  <= gen_next(s_q);
      up_q <= up_n;
      lo_q <= lo_n;
      if (idx == SW'(FF_TAP)) ff_q <= (up_n < lo_n);
    end
  end

  assign lead = (up_q < lo_q);
endmodule

// File: rtl/ff_arb_puf.sv
module ff_arb_puf
  import puf_pkg::*;
#(
  parameter int CW      = 128,
  parameter int NCH     = 2,
  parameter int DW      = 4,
  parameter int MIX_CYC = 16,
  parameter int FF_TAP  = 63,
  parameter int FF_DST  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_valid,
  output logic          ch_ready,
  input  logic [CW-1:0] ch_data,
  input  logic [31:0]   inst_seed,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_bit
);
  localparam int SW   = $clog2(CW);
  localparam int CMAX = (MIX_CYC > CW) ? MIX_CYC : CW;
  localparam int CNTW = $clog2(CMAX);
  localparam int TW   = DW + SW + 1;

  phase_t           ph_q;
  logic [CNTW-1:0]  cnt_q;
  logic [31:0]      seed_q;
  logic [CW-1:0]    ctl;
  logic [NCH-1:0]   leads;
  logic             accept;

  assign ch_ready  = (ph_q == PH_IDLE);
  assign rsp_valid = (ph_q == PH_HOLD);
  assign accept    = ch_valid & ch_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      seed_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (accept) begin
          ph_q   <= PH_MIX;
          cnt_q  <= '0;
          seed_q <= inst_seed;
        end
        PH_MIX: begin
          if (cnt_q == CNTW'(MIX_CYC - 1)) begin
            ph_q  <= PH_RACE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RACE: begin
          if (cnt_q == CNTW'(CW - 1)) ph_q <= PH_HOLD;
          else                        cnt_q <= cnt_q + 1'b1;
        end
        PH_HOLD: if (rsp_ready) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  puf_mixer #(.CW(CW)) mix_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (ch_data),
    .shift (ph_q == PH_MIX),
    .ctl   (ctl)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_chain
    localparam logic [31:0] SALT = 32'(64'(SALT_STEP) * 64'(j + 1));
    puf_race_chain #(
      .CW(CW), .DW(DW), .FF_TAP(FF_TAP), .FF_DST(FF_DST), .TW(TW), .SALT(SALT)
    ) chain_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .seed  (inst_seed),
      .step  (ph_q == PH_RACE),
      .idx   (cnt_q[SW-1:0]),
      .ctl   (ctl),
      .lead  (leads[j])
    );
  end

  assign rsp_bit = ^leads;
endmodule

// File: rtl/ff_arb_puf_chk.sv
module ff_arb_puf_chk #(
  parameter int LAT = 144
) (
  input logic clk,
  input logic rst_n,
  input logic ch_valid,
  input logic ch_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_bit
);
  logic [15:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     lat_q <= '0;
    else if (ch_valid && ch_ready)  lat_q <= '0;
    else if (!rsp_valid && lat_q != 16'hFFFF) lat_q <= lat_q + 1'b1;
  end

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready |-> !rsp_valid); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && ch_ready) |=> !ch_ready); // R2
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (lat_q == 16'(LAT))); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bit))); // R4
  AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (ch_ready && !rsp_valid)); // R4
endmodule

bind ff_arb_puf ff_arb_puf_chk #(.LAT(MIX_CYC + CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_valid  (ch_valid),
  .ch_ready  (ch_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_bit   (rsp_bit)
);

// File: tb/ff_arb_puf_tb_top.sv
`timescale 1ns/1ps
module ff_arb_puf_tb_top;
  localparam int CW = 128, NCH = 2, DW = 4, MIX_CYC = 16, FF_TAP = 63, FF_DST = 100;
  localparam int LAT = MIX_CYC + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ch_valid = 1'b0;
  logic          ch_ready;
  logic [CW-1:0] ch_data = '0;
  logic [31:0]   inst_seed = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ff_arb_puf #(.CW(CW), .NCH(NCH), .DW(DW), .MIX_CYC(MIX_CYC),
               .FF_TAP(FF_TAP), .FF_DST(FF_DST)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .ch_data(ch_data), .inst_seed(inst_seed), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_bit(rsp_bit));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model from R5..R9
  function automatic bit model(input logic [CW-1:0] chal, input logic [31:0] seed);
    logic [CW-1:0] b = chal;
    bit r = 0;
    for (int i = 0; i < MIX_CYC; i++)
      b = {b[CW-2:0], b[CW-1] ^ b[CW-3] ^ b[CW-28] ^ b[CW-30]};
    for (int j = 0; j < NCH; j++) begin
      logic [31:0] s = seed ^ (32'h9E3779B9 * 32'(j + 1));
      int up = 0, lo = 0, nu, nl;
      bit ff = 0, c;
      if (s == 0) s = 32'h1;
      for (int k = 0; k < CW; k++) begin
        c = (k == FF_DST) ? ff : b[k];
        if (c) begin nu = lo + int'(s[2*DW +: DW]); nl = up + int'(s[3*DW +: DW]); end
        else   begin nu = up + int'(s[0 +: DW]);    nl = lo + int'(s[DW +: DW]);   end
        up = nu; lo = nl;
        if (k == FF_TAP) ff = (up < lo);
        s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      end
      r ^= (up < lo);
    end
    return r;
  endfunction

  // Offer a challenge, wait for response, return latency and bit (response left pending).
  task automatic issue(input logic [CW-1:0] chal, input logic [31:0] seed,
                       output int lat, output bit rb);
    @(negedge clk);
    ch_data = chal; inst_seed = seed; ch_valid = 1'b1;
    while (!ch_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    ch_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 1000) begin @(posedge clk); lat++; #1; end
    rb = rsp_bit;
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(ch_ready === 1'b1, "R1 ch_ready after reset", ch_ready, 1);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_patterns();
    logic [CW-1:0] pats [5];
    logic [31:0]   seeds [5];
    int lat; bit rb, e;
    pats[0] = '0;                      seeds[0] = 32'h0000_0000;
    pats[1] = '1;                      seeds[1] = 32'h1234_5678;
    pats[2] = {4{32'hA5A5_5A5A}};      seeds[2] = 32'hDEAD_BEEF;
    pats[3] = {CW{1'b0}} | 128'h1;     seeds[3] = 32'h9E37_79B9;
    pats[4] = {4{32'h0F1E_2D3C}};      seeds[4] = 32'hCAFE_F00D;
    for (int i = 0; i < 5; i++) begin
      issue(pats[i], seeds[i], lat, rb);
      e = model(pats[i], seeds[i]);
      check(lat == LAT, "R3 latency", lat, LAT);
      check(rb == e, "R5 R6 R7 R8 R9 response", rb, e);
      take();
      check(ch_ready === 1'b1 && rsp_valid === 1'b0, "R4 idle after take", {ch_ready, rsp_valid}, 2);
    end
  endtask

  task automatic t_backpressure();
    int lat; bit rb, e;
    logic [CW-1:0] ch = {4{32'h3C3C_C3C3}};
    issue(ch, 32'h0BAD_F00D, lat, rb);
    e = model(ch, 32'h0BAD_F00D);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      check(rsp_valid === 1'b1 && rsp_bit === rb, "R4 response held", {rsp_valid, rsp_bit}, {1'b1, rb});
    end
    check(rb == e, "R9 response under back-pressure", rb, e);
    take();
    check(rsp_valid === 1'b0 && ch_ready === 1'b1, "R4 release", {ch_ready, rsp_valid}, 2);
  endtask

  task automatic t_busy_refuse();
    int lat = 0; bit e;
    logic [CW-1:0] first = {4{32'h1357_9BDF}};
    logic [CW-1:0] other = {4{32'hFDB9_7531}};
    @(negedge clk);
    ch_data = first; inst_seed = 32'h5555_AAAA; ch_valid = 1'b1;
    @(posedge clk); #1;
    ch_data = other; inst_seed = 32'h0F0F_0F0F;
    while (!rsp_valid && lat < 1000) begin
      check(ch_ready === 1'b0, "R2 refused while busy", ch_ready, 0);
      @(posedge clk); lat++; #1;
    end
    e = model(first, 32'h5555_AAAA);
    check(lat == LAT, "R3 latency with pending offer", lat, LAT);
    check(rsp_bit == e, "R2 response of first challenge", rsp_bit, e);
    ch_valid = 1'b0;
    take();
    repeat (5) begin
      @(posedge clk); #1;
      check(rsp_valid === 1'b0 && ch_ready === 1'b1, "R2 no late acceptance", {ch_ready, rsp_valid}, 2);
    end
  endtask

  task automatic t_repeat();
    int lat; bit r1, r2, e;
    logic [CW-1:0] ch = {4{32'h7777_1111}};
    issue(ch, 32'h2468_ACE0, lat, r1); take();
    issue(ch, 32'h2468_ACE0, lat, r2); take();
    e = model(ch, 32'h2468_ACE0);
    check(r1 == r2, "R10 repeat same response", r2, r1);
    check(r1 == e, "R10 repeat matches model", r1, e);
  endtask

  task automatic t_seed_sweep();
    int lat; bit rb, e;
    logic [CW-1:0] ch = {4{32'h8421_1248}};
    for (int i = 0; i < 8; i++) begin
      logic [31:0] sd = 32'h1000_0001 * 32'(i + 3);
      issue(ch, sd, lat, rb);
      e = model(ch, sd);
      check(rb == e, "R6 R7 R9 seed sweep", rb, e);
      take();
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_patterns();
    t_backpressure();
    t_busy_refuse();
    t_repeat();
    t_seed_sweep();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule